// File: doc/BRIEF.md
# Complex Radix-2 Butterfly Functional Unit

This block is a custom multiple-input, multiple-output functional unit that sits beside a VLIW register file and computes one radix-2 complex butterfly. It takes three complex operands, the upper input `a`, the lower input `b` and the twiddle `w`, as six signed Q1.15 words. It returns the two complex results `a + b*w` and `a - b*w` as four words. The register file has at most four read ports and two write ports in use by this unit in any cycle, so operands come in, and results go out, over several cycles.

A `start` pulse in an idle cycle presents `b` and `w` on the four read ports. The four partial products go through three-cycle pipelined multipliers and are then combined into `b*w`. The unit asks for `a` on two read ports only when the product is ready, forms the sum and the difference, and writes them two words per cycle. In rigid mode every read and write sits in a fixed cycle, and the whole operation takes eight cycles. In flexible mode a `stall` input can hold the `a` read and each of the two write cycles, so the scheduler may push any of these stages later.

Top module: `bfly_fu`

## Requirements
- R1: After reset `busy`, `a_req` and `wr_valid` are 0, and they stay 0 while no operation is running.
- R2: A `start` in an idle cycle takes `b` and `w` from the read ports in that same cycle: `rd0`=Re(b), `rd1`=Im(b), `rd2`=Re(w), `rd3`=Im(w).
- R3: In rigid mode `a_req` is high only in cycle 5, counting the start cycle as 0, and `rd0`=Re(a) and `rd1`=Im(a) are sampled in that cycle.
- R4: In rigid mode `wr_valid` is high in cycles 6 and 7 only. In cycle 6 `wr0`/`wr1` carry Re/Im of a+b·w. In cycle 7 they carry Re/Im of a−b·w. `busy` is low from cycle 8, so the latency is 8 cycles.
- R5: Each real product x·y is formed at full width, rounded by adding 2^14 and shifting right arithmetically by 15, and saturated to [−32768, 32767]. Re(b·w) = sat(Re b·Re w − Im b·Im w) and Im(b·w) = sat(Re b·Im w + Im b·Re w), each built from the rounded products.
- R6: Each output word is the sum or difference of two 16-bit words, saturated to [−32768, 32767].
- R7: In flexible mode `a_req` is raised in cycle 5 and held. `a` is sampled in the first cycle, from cycle 5 on, in which `stall` is 0, and `a_req` drops in the next cycle.
- R8: In flexible mode each write cycle happens only in a cycle with `stall` at 0, later than the `a` sample. The sum is written first and then the difference, and `busy` drops in the cycle after the second write.
- R9: In rigid mode `stall` has no effect on timing or on results.
- R10: A `start` while `busy` is high is ignored and does not disturb the running operation. A `start` in the cycle right after the last write is accepted.
- R11: The mode is taken from `flex_mode` (1 = flexible) in the start cycle. Later changes of `flex_mode` do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (accepted only when idle) |
| flex_mode | input | 1 | 1 = flexible timing, 0 = rigid, sampled at start |
| stall | input | 1 | Holds the a-read or a write stage in flexible mode |
| rd0 | input | 16 | Read port 0: Re(b) at start, Re(a) on a-read |
| rd1 | input | 16 | Read port 1: Im(b) at start, Im(a) on a-read |
| rd2 | input | 16 | Read port 2: Re(w) at start |
| rd3 | input | 16 | Read port 3: Im(w) at start |
| a_req | output | 1 | The unit wants `a` on rd0/rd1 |
| wr_valid | output | 1 | wr0/wr1 hold a result pair to write |
| wr0 | output | 16 | Real part of the current result |
| wr1 | output | 16 | Imaginary part of the current result |
| busy | output | 1 | An operation is in progress |

## Verification
The assertions take it that `start` is a level seen on a clock edge. They also take it that, in rigid mode, the environment does not drop the operation once it is accepted, because the fixed-latency checks count cycles from an idle-cycle start with `flex_mode` low. The stimulus keeps `a` on rd0/rd1 only while `a_req` is high and puts changing filler on the ports at all other times, so a sample taken in the wrong cycle shows up as a wrong result. Stall patterns in flexible mode are drawn with a zero in every nibble, so no stage is held for more than three cycles in a row, and extra `start` pulses and mode flips are injected into operations that are already running.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int DW   = 16;
  localparam int FRAC = DW - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MUL, ST_CMB, ST_AREAD, ST_WR0, ST_WR1
  } bfly_st_e;

  localparam logic signed [DW:0]   NMAX  = (DW+1)'(2**(DW-1) - 1);
  localparam logic signed [DW:0]   NMIN  = -(DW+1)'(2**(DW-1));
  localparam logic signed [2*DW:0] WMAX  = (2*DW+1)'(2**(DW-1) - 1);
  localparam logic signed [2*DW:0] WMIN  = -(2*DW+1)'(2**(DW-1));
  localparam logic [2*DW:0]        RND_K = (2*DW+1)'(1) << (FRAC - 1);

  // clamp a one-bit-wide sum back to DW bits
  function automatic logic signed [DW-1:0] clamp_n(input logic signed [DW:0] v);
    if (v > NMAX) return NMAX[DW-1:0];
    if (v < NMIN) return NMIN[DW-1:0];
    return v[DW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] add_sat(input logic signed [DW-1:0] x,
                                                   input logic signed [DW-1:0] y);
    logic signed [DW:0] v;
    v = {x[DW-1], x} + {y[DW-1], y};
    return clamp_n(v);
  endfunction

  function automatic logic signed [DW-1:0] sub_sat(input logic signed [DW-1:0] x,
                                                   input logic signed [DW-1:0] y);
    logic signed [DW:0] v;
    v = {x[DW-1], x} - {y[DW-1], y};
    return clamp_n(v);
  endfunction

  // round a full-width product half up and saturate to DW bits
  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [2*DW-1:0] p);
    logic signed [2*DW:0] t;
    logic signed [2*DW:0] s;
    t = {p[2*DW-1], p} + RND_K;
    s = t >>> FRAC;
    if (s > WMAX) return WMAX[DW-1:0];
    if (s < WMIN) return WMIN[DW-1:0];
    return s[DW-1:0];
  endfunction
endpackage

// File: rtl/bfly_mulpipe.sv
module bfly_mulpipe
  import bfly_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] y,
  output logic signed [DW-1:0] q
);
  logic signed [2*DW-1:0] prod_c;
  logic signed [DW-1:0]   rnd_c;
  logic signed [DW-1:0]   stg_q [LAT];

  always_comb begin
    prod_c = x * y;
    rnd_c  = rnd_sat(prod_c);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      stg_q[0] <= rnd_c;
      for (int i = 1; i < LAT; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[LAT-1];
endmodule

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
#(
  parameter int MUL_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic flex_mode,
  input  logic stall,
  output logic busy,
  output logic ld_bw,
  output logic mul_en,
  output logic ld_cp,
  output logic a_req,
  output logic ld_a,
  output logic wr_valid,
  output logic wr_sel,
  output logic op_flex
);
  localparam int CW = (MUL_LAT > 1) ? $clog2(MUL_LAT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(MUL_LAT - 1);

  bfly_st_e      state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flex_q;
  logic          hold;

  assign hold = flex_q & stall;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    ld_bw    = 1'b0;
    mul_en   = 1'b0;
    ld_cp    = 1'b0;
    a_req    = 1'b0;
    ld_a     = 1'b0;
    wr_valid = 1'b0;
    wr_sel   = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        ld_bw   = 1'b1;
        cnt_d   = '0;
        state_d = ST_MUL;
      end
      ST_MUL: begin
        mul_en = 1'b1;
        if (cnt_q == CNT_LAST) state_d = ST_CMB;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_CMB: begin
        ld_cp   = 1'b1;
        state_d = ST_AREAD;
      end
      ST_AREAD: begin
        a_req = 1'b1;
        if (!hold) begin
          ld_a    = 1'b1;
          state_d = ST_WR0;
        end
      end
      ST_WR0: if (!hold) begin
        wr_valid = 1'b1;
        state_d  = ST_WR1;
      end
      ST_WR1: begin
        wr_sel = 1'b1;
        if (!hold) begin
          wr_valid = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      flex_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (ld_bw) flex_q <= flex_mode;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign op_flex = flex_q;
endmodule

// File: rtl/bfly_fu.sv
module bfly_fu
  import bfly_pkg::*;
#(
  parameter int MUL_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          flex_mode,
  input  logic          stall,
  input  logic [DW-1:0] rd0,
  input  logic [DW-1:0] rd1,
  input  logic [DW-1:0] rd2,
  input  logic [DW-1:0] rd3,
  output logic          a_req,
  output logic          wr_valid,
  output logic [DW-1:0] wr0,
  output logic [DW-1:0] wr1,
  output logic          busy
);
  localparam int NUM_MUL = 4;

  logic rst_meta_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  logic ld_bw, mul_en, ld_cp, ld_a, wr_sel, op_flex;

  bfly_ctrl #(.MUL_LAT(MUL_LAT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_ns),
    .start    (start),
    .flex_mode(flex_mode),
    .stall    (stall),
    .busy     (busy),
    .ld_bw    (ld_bw),
    .mul_en   (mul_en),
    .ld_cp    (ld_cp),
    .a_req    (a_req),
    .ld_a     (ld_a),
    .wr_valid (wr_valid),
    .wr_sel   (wr_sel),
    .op_flex  (op_flex)
  );

  logic signed [DW-1:0] b_re_q, b_im_q, w_re_q, w_im_q;
  always_ff @(posedge clk) begin
    if (ld_bw) begin
      b_re_q <= $signed(rd0);
      b_im_q <= $signed(rd1);
      w_re_q <= $signed(rd2);
      w_im_q <= $signed(rd3);
    end
  end

  // partial products: 0 = re*re, 1 = im*im, 2 = re(b)*im(w), 3 = im(b)*re(w)
  logic signed [DW-1:0] mx [NUM_MUL];
  logic signed [DW-1:0] my [NUM_MUL];
  logic signed [DW-1:0] mq [NUM_MUL];

  always_comb begin
    mx[0] = b_re_q;  my[0] = w_re_q;
    mx[1] = b_im_q;  my[1] = w_im_q;
    mx[2] = b_re_q;  my[2] = w_im_q;
    mx[3] = b_im_q;  my[3] = w_re_q;
  end

  for (genvar gi = 0; gi < NUM_MUL; gi++) begin : g_mul
    bfly_mulpipe #(.LAT(MUL_LAT)) u_mul (
      .clk(clk),
      .en (mul_en),
      .x  (mx[gi]),
      .y  (my[gi]),
      .q  (mq[gi])
    );
  end

  logic signed [DW-1:0] cp_re_q, cp_im_q;
  always_ff @(posedge clk) begin
    if (ld_cp) begin
      cp_re_q <= sub_sat(mq[0], mq[1]);
      cp_im_q <= add_sat(mq[2], mq[3]);
    end
  end

  logic signed [DW-1:0] a_re, a_im;
  logic signed [DW-1:0] sp_re_q, sp_im_q, dn_re_q, dn_im_q;
  assign a_re = $signed(rd0);
  assign a_im = $signed(rd1);

  always_ff @(posedge clk) begin
    if (ld_a) begin
      sp_re_q <= add_sat(a_re, cp_re_q);
      sp_im_q <= add_sat(a_im, cp_im_q);
      dn_re_q <= sub_sat(a_re, cp_re_q);
      dn_im_q <= sub_sat(a_im, cp_im_q);
    end
  end

  assign wr0 = wr_sel ? dn_re_q : sp_re_q;
  assign wr1 = wr_sel ? dn_im_q : sp_im_q;
endmodule

// File: rtl/bfly_fu_chk.sv
module bfly_fu_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic flex_mode,
  input logic stall,
  input logic busy,
  input logic a_req,
  input logic wr_valid,
  input logic op_flex
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !a_req));

  // R3
  rigid_aread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !flex_mode) |-> ##5 a_req);

  // R4
  rigid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !flex_mode) |-> ##6 wr_valid ##1 wr_valid ##1 !busy);

  // R7
  a_take_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && !(op_flex && stall)) |=> !a_req);

  // R8
  flex_stall_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && op_flex) |-> !stall);

  // R10
  end_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wr_valid));
endmodule

bind bfly_fu bfly_fu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_ns),
  .start    (start),
  .flex_mode(flex_mode),
  .stall    (stall),
  .busy     (busy),
  .a_req    (a_req),
  .wr_valid (wr_valid),
  .op_flex  (op_flex)
);

// File: tb/bfly_fu_tb_top.sv
module bfly_fu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, flex_mode, stall;
  logic [15:0] rd0, rd1, rd2, rd3;
  logic        a_req, wr_valid, busy;
  logic [15:0] wr0, wr1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bfly_fu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .flex_mode(flex_mode), .stall(stall),
    .rd0(rd0), .rd1(rd1), .rd2(rd2), .rd3(rd3),
    .a_req(a_req), .wr_valid(wr_valid), .wr0(wr0), .wr1(wr1), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] tb_sat(input longint v);
    if (v > 32767)  return 16'sh7fff;
    if (v < -32768) return 16'sh8000;
    return v[15:0];
  endfunction

  function automatic logic signed [15:0] tb_mul(input logic signed [15:0] x,
                                                input logic signed [15:0] y);
    longint p;
    p = longint'(x) * longint'(y);
    return tb_sat((p + 16384) >>> 15);
  endfunction

  // one butterfly; entered and left just after a falling edge
  task automatic run_op(input logic signed [15:0] ar, ai, br, bi, w_r, w_i,
                        input bit flex, input logic [15:0] spat, input bit poke);
    logic signed [15:0] cre, cim, e_sr, e_si, e_dr, e_di;
    logic [31:0] got [2];
    int wk [2];
    int take_k, nw, k, end_k, x_take, x_w0, x_w1;
    cre  = tb_sat(longint'(tb_mul(br, w_r)) - longint'(tb_mul(bi, w_i)));
    cim  = tb_sat(longint'(tb_mul(br, w_i)) + longint'(tb_mul(bi, w_r)));
    e_sr = tb_sat(longint'(ar) + longint'(cre));
    e_si = tb_sat(longint'(ai) + longint'(cim));
    e_dr = tb_sat(longint'(ar) - longint'(cre));
    e_di = tb_sat(longint'(ai) - longint'(cim));
    if (flex) begin
      x_take = 5;  while (spat[x_take % 16]) x_take++;
      x_w0 = x_take + 1; while (spat[x_w0 % 16]) x_w0++;
      x_w1 = x_w0 + 1;   while (spat[x_w1 % 16]) x_w1++;
    end else begin
      x_take = 5; x_w0 = 6; x_w1 = 7;
    end
    start = 1'b1; flex_mode = flex; stall = ~flex;
    rd0 = br; rd1 = bi; rd2 = w_r; rd3 = w_i;
    take_k = -1; nw = 0; end_k = -1;
    wk[0] = -1; wk[1] = -1; got[0] = '0; got[1] = '0;
    for (k = 1; k < 60; k++) begin
      @(negedge clk);
      start     = poke && (k == 3 || k == 7);
      flex_mode = ~flex;                         // R11: must not matter
      stall     = flex ? spat[k % 16] : k[0];    // R9: ignored in rigid mode
      rd0 = 16'(k * 771); rd1 = 16'(k * 4093 + 5); rd2 = 16'(k * 13); rd3 = 16'(~k);
      if (a_req) begin
        rd0 = ar; rd1 = ai;
        if (take_k < 0 && !(flex && stall)) take_k = k;
      end
      #1;
      if (wr_valid) begin
        if (nw < 2) begin got[nw] = {wr0, wr1}; wk[nw] = k; end
        nw++;
      end
      if (!busy) begin end_k = k; break; end
    end
    start = 1'b0;
    chk(take_k == x_take, flex ? "R7 a sample cycle" : "R3 a sample cycle", take_k, x_take);
    chk(nw == 2, "R4/R8 write count", nw, 2);
    chk(wk[0] == x_w0 && wk[1] == x_w1, flex ? "R8 write cycles" : "R4 write cycles",
        {wk[0][15:0], wk[1][15:0]}, {x_w0[15:0], x_w1[15:0]});
    chk(end_k == x_w1 + 1, "R4 busy end / R10", end_k, x_w1 + 1);
    chk(got[0] == {e_sr, e_si}, "R5 R6 sum a+bw", got[0], {e_sr, e_si});
    chk(got[1] == {e_dr, e_di}, "R5 R6 diff a-bw (R2 operands)", got[1], {e_dr, e_di});
  endtask

  initial begin
    logic signed [15:0] vals [7];
    logic [31:0] lcg;
    vals = '{16'sh8000, -16'sd16384, -16'sd1, 16'sd0, 16'sd1, 16'sd12345, 16'sh7fff};
    start = 0; flex_mode = 0; stall = 0; rd0 = 0; rd1 = 0; rd2 = 0; rd3 = 0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: quiet after reset
    chk(!busy && !a_req && !wr_valid, "R1 reset state", {busy, a_req, wr_valid}, 0);
    @(negedge clk);
    // near-exhaustive rigid sweep over corner values (R2..R6, R9, R10, R11)
    for (int i0 = 0; i0 < 7; i0++)
      for (int i1 = 0; i1 < 7; i1++)
        for (int i2 = 0; i2 < 7; i2++)
          for (int i3 = 0; i3 < 7; i3++)
            run_op(vals[(i0 + i3) % 7], vals[(i1 + i2 + 3) % 7],
                   vals[i0], vals[i1], vals[i2], vals[i3],
                   1'b0, 16'h0, ((i0 + i1 + i2 + i3) % 5) == 0);
    // flexible mode with stall patterns (R7, R8, R10, R11)
    lcg = 32'h1234_5678;
    for (int j = 0; j < 300; j++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      run_op(vals[j % 7], vals[(j / 7) % 7], vals[(j / 3) % 7], vals[(j + 2) % 7],
             16'(lcg[31:16] ^ lcg[15:0]), vals[(j / 11) % 7],
             1'b1, lcg[23:8] & 16'h7777, j[0]);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule